// File: doc/BRIEF.md
# Clock-Domain Level Synchronizer with Edge Strobes

This block carries one slowly changing, asynchronous control bit (a start or stop request, a switch, a status line from another domain) into the local clock domain. The bit passes through a short series chain of retiming flip-flops. Only the settled end of that chain is used by the rest of the block. The block drives a retimed copy of the level, together with two single-cycle strobes that mark each upward and each downward change.

The flip-flop that captures the raw input may go metastable. Its output therefore drives one load only, which is the data input of the second flip-flop. Everything downstream reads only the last stage and one history register that follows it, so every consumer sees the same settled value.

The input must hold each level for at least two clock periods. Downstream logic must tolerate a delay of a few cycles between an input change and the matching strobe. A synchronous reset clears the whole path.

Top module: `sync_edge_strobe`

## Requirements
- R1: When rst_i is sampled high at a rising clock edge, every retiming stage and the edge history are cleared, so level_o, rise_o and fall_o are all 0 after that edge.
- R2: With the default depth of three stages, an input change that is set up before a clock edge appears on level_o after the third rising edge, counting that edge. For a change with unknown phase, the delay measured in clock edges from the change is 3 or 4.
- R3: rise_o is 1 for exactly one clock cycle for each low-to-high change of level_o, in the first cycle in which level_o reads 1.
- R4: fall_o is 1 for exactly one clock cycle for each high-to-low change of level_o, in the first cycle in which level_o reads 0.
- R5: rise_o and fall_o are never 1 in the same cycle.
- R6: Outside reset, level_o changes only in a cycle that carries the matching strobe, and no strobe appears without a change of level_o.
- R7: Driving async_i to the level it already holds produces no strobe and leaves level_o unchanged.
- R8: If reset is released while async_i is held at 1, exactly one rise_o strobe follows, on the third rising edge after release.
- R9: Asserting reset while level_o is 1 drives level_o to 0 without any fall_o strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Destination-domain clock |
| rst_i | input | 1 | Synchronous reset, active high |
| async_i | input | 1 | Asynchronous input bit, each level held at least two clock periods |
| level_o | output | 1 | Input level retimed into the clock domain |
| rise_o | output | 1 | One-cycle strobe on a low-to-high change |
| fall_o | output | 1 | One-cycle strobe on a high-to-low change |

## Verification
The bench changes the input at several phases inside the clock period and counts edges until the level appears. A chain that is too short or too long lands outside the 3-or-4 window. A detector that compares the wrong stages produces strobes that are two cycles wide or that fire in the wrong cycle. Re-driving the same level catches a detector that fires on activity rather than on change. The reset cases catch a history register that is left uncleared: it would emit a spurious falling strobe when reset hits a high level, or miss or double the rising strobe when reset is released with the input high.

// File: rtl/sync_edge_pkg.sv
package sync_edge_pkg;

    // Kind of change seen between the settled level and its history.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_kind_t;

    // History held by the detector: the settled level one cycle ago.
    typedef struct packed {
        logic prev;
    } edge_state_t;

endpackage

// File: rtl/sync_retime_chain.sv
module sync_retime_chain #(
    parameter int STAGES = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] stage_q;

    // Stage 0 is read only by stage 1; nothing else taps it.
    always_comb begin
        stage_d = {stage_q[STAGES-2:0], async_i};
        if (rst_i) begin
            stage_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        stage_q <= stage_d;
    end

    assign sync_o = stage_q[LAST];

    AST_CHAIN_CLEARED: assert property (@(posedge clk_i)
        rst_i |=> (stage_q == '0)); // R1

endmodule

// File: rtl/sync_edge_detect.sv
module sync_edge_detect
    import sync_edge_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    edge_state_t state_d;
    edge_state_t state_q;
    edge_kind_t  kind;

    always_comb begin
        state_d.prev = level_i;
        if (rst_i) begin
            state_d.prev = 1'b0;
        end
        if (level_i && !state_q.prev) begin
            kind = EDGE_RISE;
        end else if (!level_i && state_q.prev) begin
            kind = EDGE_FALL;
        end else begin
            kind = EDGE_NONE;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign rise_o = (kind == EDGE_RISE);
    assign fall_o = (kind == EDGE_FALL);

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({rise_o, fall_o})); // R5

    AST_RISE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o); // R3

    AST_FALL_ONE_WIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_o |=> !fall_o); // R4

endmodule

// File: rtl/sync_edge_strobe.sv
module sync_edge_strobe #(
    parameter int SYNC_STAGES = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic settled;

    sync_retime_chain #(
        .STAGES (SYNC_STAGES)
    ) chain_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (async_i),
        .sync_o  (settled)
    );

    sync_edge_detect detect_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (settled),
        .rise_o  (rise_o),
        .fall_o  (fall_o)
    );

    assign level_o = settled;

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (!level_o && !rise_o && !fall_o)); // R1

    AST_RISE_WITH_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |-> level_o); // R3

    AST_FALL_WITH_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_o |-> !level_o); // R4

    AST_LEVEL_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !rise_o && !fall_o) |-> $stable(level_o)); // R6

endmodule

// File: tb/sync_edge_strobe_tb_top.sv
`timescale 1ns/1ps
module sync_edge_strobe_tb_top;

    logic clk_i   = 1'b0;
    logic rst_i   = 1'b1;
    logic async_i = 1'b0;
    logic level_o;
    logic rise_o;
    logic fall_o;

    int checks   = 0;
    int failures = 0;
    int rise_seen = 0;
    int fall_seen = 0;
    int both_seen = 0;
    int rise_exp  = 0;
    int fall_exp  = 0;
    logic exp_lvl = 1'b0;

    always #4 clk_i = ~clk_i;

    sync_edge_strobe dut_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (async_i),
        .level_o (level_o),
        .rise_o  (rise_o),
        .fall_o  (fall_o)
    );

    // Strobe monitor, sampled half a period away from the active edge.
    always @(negedge clk_i) begin
        if (rise_o) rise_seen++;
        if (fall_o) fall_seen++;
        if (rise_o && fall_o) both_seen++;
    end

    typedef struct packed {
        logic       lvl;
        logic [2:0] ofs;
        logic [3:0] hold;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd1, 4'd0},
        '{1'b0, 3'd5, 4'd2},
        '{1'b1, 3'd7, 4'd1},
        '{1'b1, 3'd3, 4'd0},
        '{1'b0, 3'd2, 4'd0},
        '{1'b1, 3'd6, 4'd3},
        '{1'b0, 3'd4, 4'd5},
        '{1'b1, 3'd1, 4'd0},
        '{1'b0, 3'd7, 4'd1},
        '{1'b0, 3'd3, 4'd0},
        '{1'b1, 3'd5, 4'd2},
        '{1'b0, 3'd2, 4'd0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Count edges until level_o reaches lvl; returns the edge count.
    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        do begin
            @(posedge clk_i);
            #1;
            n++;
        end while (level_o != lvl && n < 10);
    endtask

    task automatic drive(input logic lvl, input int ofs, input int hold);
        int n;
        @(posedge clk_i);
        #(ofs);
        async_i = lvl;
        if (lvl != exp_lvl) begin
            wait_level(lvl, n);
            check(n == 3 || n == 4, "R2", "edges to level", n, 3);
            if (lvl) begin
                rise_exp++;
                check(rise_o == 1'b1 && fall_o == 1'b0, "R3", "rise strobe with new level",
                      int'(rise_o), 1);
            end else begin
                fall_exp++;
                check(fall_o == 1'b1 && rise_o == 1'b0, "R4", "fall strobe with new level",
                      int'(fall_o), 1);
            end
            @(posedge clk_i);
            #1;
            check(!rise_o && !fall_o, lvl ? "R3" : "R4", "strobe one cycle wide",
                  int'(rise_o) + int'(fall_o), 0);
        end else begin
            for (int i = 0; i < 5; i++) begin
                @(posedge clk_i);
                #1;
                check(!rise_o && !fall_o && level_o == lvl, "R7", "same level no strobe",
                      int'(rise_o) + int'(fall_o), 0);
            end
        end
        exp_lvl = lvl;
        repeat (hold) @(posedge clk_i);
    endtask

    initial begin : watchdog
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        report();
    end

    initial begin : main
        int n;
        // R1: reset state with the input already high.
        async_i = 1'b1;
        repeat (4) @(posedge clk_i);
        #1;
        check(!level_o && !rise_o && !fall_o, "R1", "outputs cleared in reset",
              int'(level_o) + int'(rise_o) + int'(fall_o), 0);

        // R8: release with the input held high gives one rising strobe.
        rst_i = 1'b0;
        wait_level(1'b1, n);
        check(n == 3, "R8", "edges after release", n, 3);
        check(rise_o == 1'b1, "R8", "rise strobe after release", int'(rise_o), 1);
        rise_exp++;
        @(posedge clk_i);
        #1;
        check(rise_o == 1'b0, "R8", "single rise after release", int'(rise_o), 0);
        exp_lvl = 1'b1;

        // Vector table: unaligned phases, changes and same-level re-drives.
        for (int v = 0; v < NVEC; v++) begin
            drive(VECS[v].lvl, int'(VECS[v].ofs), int'(VECS[v].hold));
        end

        // R9: reset while the level is high drops it with no falling strobe.
        drive(1'b1, 2, 2);
        @(posedge clk_i);
        #1;
        rst_i = 1'b1;
        @(posedge clk_i);
        #1;
        check(level_o == 1'b0, "R9", "level cleared by reset", int'(level_o), 0);
        check(fall_o == 1'b0, "R9", "no fall strobe on reset", int'(fall_o), 0);
        repeat (2) @(posedge clk_i);
        #1;
        check(fall_o == 1'b0 && rise_o == 1'b0, "R1", "quiet while in reset",
              int'(fall_o) + int'(rise_o), 0);
        async_i = 1'b0;
        rst_i   = 1'b0;
        exp_lvl = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk_i);
            #1;
            check(!rise_o && !fall_o && !level_o, "R7", "low after release stays quiet",
                  int'(rise_o) + int'(fall_o) + int'(level_o), 0);
        end
        drive(1'b1, 4, 1);

        // R5 / R6: totals from the strobe monitor.
        repeat (2) @(posedge clk_i);
        #1;
        check(both_seen == 0, "R5", "strobes overlapped", both_seen, 0);
        check(rise_seen == rise_exp, "R6", "rise strobe count", rise_seen, rise_exp);
        check(fall_seen == fall_exp, "R6", "fall strobe count", fall_seen, fall_exp);
        report();
    end

endmodule